// File: doc/BRIEF.md
# Remote Path Defect Code Encoder

This block builds the three-bit remote defect indication that a path terminating transmitter places in the path status overhead byte of every outgoing frame. It takes six locally detected path defect flags: alarm indication, loss of pointer, trace identifier mismatch, unequipped, payload label mismatch and loss of cell delineation. It sorts them into one of four defect classes by a fixed priority and turns the chosen class into a code. It then writes that code into bits [3:1] of the status byte as the byte passes through. All other bits of the byte pass through unchanged.

Two coding modes are supported. In enhanced mode each defect class has its own code, and the no-defect state has a code of its own (001). In legacy mode the block only reports server defects, and it sends 000 when there is no server defect. The chosen class and the mode are captured only when a frame strobe is seen. As a result the field never changes in the middle of a frame. With frame periods in the microsecond range, this capture point meets the 100 ms limit for starting and stopping a code with a wide margin.

A small state machine, `rdi_frame_fsm`, holds the class currently being sent. Its states are `ST_CLEAR`, `ST_PAYLOAD`, `ST_CONNECT` and `ST_SERVER`. There is one named transition, "strobe refresh": on a cycle where `frame_sync` is high, the machine moves from any state to the state for the highest-priority defect present. On a cycle where `frame_sync` is low, the machine stays in its current state, which is the "hold" transition. The coding mode is captured in the same cycle as the class.

Top module: `rdi_path_encoder`

## Requirements
- R1: After reset the code field (`rdi_code`) is 001, which is the enhanced no-defect value.
- R2: In enhanced mode, if alarm indication or loss of pointer is present at a strobe, the code becomes 101.
- R3: In enhanced mode, if trace mismatch or unequipped is present at a strobe and there is no server defect, the code becomes 110.
- R4: In enhanced mode, if payload label mismatch or loss of cell delineation is present at a strobe and no higher-priority defect is present, the code becomes 010.
- R5: When defects from several classes are present together, the class chosen follows the order server, then connectivity, then payload.
- R6: In enhanced mode, if no defect is present at a strobe, the code becomes 001.
- R7: In legacy mode the code is 100 when any server defect is present and 000 otherwise. Connectivity and payload defects produce 000 in this mode, and the codes 110 and 010 never appear.
- R8: The code changes only in the clock cycle after a strobe edge. Changes to the defect flags or the mode between strobes have no effect on `rdi_code` or `byte_out`.
- R9: `byte_out[3:1]` carries the code, with bit 3 as the most significant bit. `byte_out[7:4]` and `byte_out[0]` equal the matching bits of `byte_in` in the same cycle.
- R10: A change of mode takes effect at the next strobe, using the defects present at that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | One-cycle frame boundary strobe |
| legacy_mode | input | 1 | 1 selects legacy coding, 0 selects enhanced coding |
| def_ais | input | 1 | Local alarm indication defect |
| def_lop | input | 1 | Local loss of pointer defect |
| def_tim | input | 1 | Local trace identifier mismatch defect |
| def_uneq | input | 1 | Local unequipped defect |
| def_plm | input | 1 | Local payload label mismatch defect |
| def_lcd | input | 1 | Local loss of cell delineation defect |
| byte_in | input | 8 | Path status byte before merging |
| byte_out | output | 8 | Path status byte with the code in bits [3:1] |
| rdi_code | output | 3 | Code currently being sent |

## Verification
The bench applies every mix of defect classes. This catches a priority encoder that lets a payload or connectivity flag win over a server flag, which would send 010 or 110 while a server defect is active. In legacy mode it applies connectivity and payload defects on their own. A design that copied the enhanced codes into legacy mode would emit 110 or 010 there, and one that kept the enhanced idle value would emit 001 instead of 000. Between strobes the bench toggles the flags and the mode, and it drives byte patterns whose pass-through bits alternate. A design that updated the code mid-frame, or that wrote the field at the wrong bit offset, would show a changed `byte_out`.

// File: rtl/rdi_enc_pkg.sv
package rdi_enc_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        ST_CLEAR   = 2'd0,
        ST_PAYLOAD = 2'd1,
        ST_CONNECT = 2'd2,
        ST_SERVER  = 2'd3
    } defect_cls_e;

    localparam logic [CODE_W-1:0] ENH_SERVER  = 3'b101;
    localparam logic [CODE_W-1:0] ENH_CONNECT = 3'b110;
    localparam logic [CODE_W-1:0] ENH_PAYLOAD = 3'b010;
    localparam logic [CODE_W-1:0] ENH_CLEAR   = 3'b001;
    localparam logic [CODE_W-1:0] LEG_SERVER  = 3'b100;
    localparam logic [CODE_W-1:0] LEG_CLEAR   = 3'b000;
endpackage

// File: rtl/rdi_prio_sel.sv
module rdi_prio_sel
    import rdi_enc_pkg::*;
(
    input  logic        ais,
    input  logic        lop,
    input  logic        tim,
    input  logic        uneq,
    input  logic        plm,
    input  logic        lcd,
    output defect_cls_e req_cls
);
    logic server_any;
    logic connect_any;
    logic payload_any;

    assign server_any  = ais | lop;
    assign connect_any = tim | uneq;
    assign payload_any = plm | lcd;

    always_comb begin
        if (server_any)       req_cls = ST_SERVER;
        else if (connect_any) req_cls = ST_CONNECT;
        else if (payload_any) req_cls = ST_PAYLOAD;
        else                  req_cls = ST_CLEAR;
    end
endmodule

// File: rtl/rdi_frame_fsm.sv
module rdi_frame_fsm
    import rdi_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              legacy_mode,
    input  defect_cls_e       req_cls,
    output logic [CODE_W-1:0] code
);
    defect_cls_e state_q;
    defect_cls_e state_d;
    logic        legacy_q;

    always_comb begin
        state_d = frame_sync ? req_cls : state_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_CLEAR;
            legacy_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (frame_sync) legacy_q <= legacy_mode;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_SERVER:  code = legacy_q ? LEG_SERVER : ENH_SERVER;
            ST_CONNECT: code = legacy_q ? LEG_CLEAR  : ENH_CONNECT;
            ST_PAYLOAD: code = legacy_q ? LEG_CLEAR  : ENH_PAYLOAD;
            ST_CLEAR:   code = legacy_q ? LEG_CLEAR  : ENH_CLEAR;
            default:    code = ENH_CLEAR;
        endcase
    end

    assert_hold_between_strobes_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(code));

    assert_legacy_no_class_codes_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (frame_sync && legacy_mode) |=> (code == LEG_SERVER || code == LEG_CLEAR));
endmodule

// File: rtl/rdi_byte_merge.sv
module rdi_byte_merge #(
    parameter int BYTE_W    = 8,
    parameter int FIELD_LSB = 1,
    parameter int FIELD_W   = 3
) (
    input  logic [BYTE_W-1:0]  byte_in,
    input  logic [FIELD_W-1:0] field,
    output logic [BYTE_W-1:0]  byte_out
);
    localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        if (i >= FIELD_LSB && i <= FIELD_MSB) begin : g_field
            assign byte_out[i] = field[i-FIELD_LSB];
        end else begin : g_pass
            assign byte_out[i] = byte_in[i];
        end
    end
endmodule

// File: rtl/rdi_path_encoder.sv
module rdi_path_encoder
    import rdi_enc_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int FIELD_LSB = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              legacy_mode,
    input  logic              def_ais,
    input  logic              def_lop,
    input  logic              def_tim,
    input  logic              def_uneq,
    input  logic              def_plm,
    input  logic              def_lcd,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic [CODE_W-1:0] rdi_code
);
    defect_cls_e req_cls;

    rdi_prio_sel u_prio (
        .ais     (def_ais),
        .lop     (def_lop),
        .tim     (def_tim),
        .uneq    (def_uneq),
        .plm     (def_plm),
        .lcd     (def_lcd),
        .req_cls (req_cls)
    );

    rdi_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_sync  (frame_sync),
        .legacy_mode (legacy_mode),
        .req_cls     (req_cls),
        .code        (rdi_code)
    );

    rdi_byte_merge #(
        .BYTE_W    (BYTE_W),
        .FIELD_LSB (FIELD_LSB),
        .FIELD_W   (CODE_W)
    ) u_merge (
        .byte_in  (byte_in),
        .field    (rdi_code),
        .byte_out (byte_out)
    );

    assert_server_wins_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (frame_sync && !legacy_mode && (def_ais || def_lop)) |=> (rdi_code == ENH_SERVER));

    assert_idle_enhanced_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (frame_sync && !legacy_mode && !(def_ais || def_lop || def_tim || def_uneq || def_plm || def_lcd))
        |=> (rdi_code == ENH_CLEAR));

    assert_field_carried_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        byte_out[FIELD_LSB +: CODE_W] == rdi_code);

    assert_no_enhanced_class_in_legacy_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (frame_sync && legacy_mode && !(def_ais || def_lop)) |=> (rdi_code == LEG_CLEAR));
endmodule

// File: tb/rdi_path_encoder_tb.sv
module rdi_path_encoder_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       legacy_mode = 1'b0;
    logic [5:0] defs = 6'b0;
    logic [7:0] byte_in = 8'h00;
    logic [7:0] byte_out;
    logic [2:0] rdi_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [2:0] model_code = 3'b001;
    event       chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdi_path_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .legacy_mode(legacy_mode),
        .def_ais(defs[5]), .def_lop(defs[4]), .def_tim(defs[3]), .def_uneq(defs[2]),
        .def_plm(defs[1]), .def_lcd(defs[0]),
        .byte_in(byte_in), .byte_out(byte_out), .rdi_code(rdi_code)
    );

    function automatic logic [2:0] ref_code(input logic [5:0] d, input logic leg);
        if (d[5] || d[4]) return leg ? 3'b100 : 3'b101;
        if (leg)          return 3'b000;
        if (d[3] || d[2]) return 3'b110;
        if (d[1] || d[0]) return 3'b010;
        return 3'b001;
    endfunction

    function automatic logic [7:0] merged(input logic [7:0] b, input logic [2:0] c);
        return {b[7:4], c, b[0]};
    endfunction

    // Driver: one frame with strobe, then queue the expected byte.
    task automatic frame(input logic [5:0] d, input logic leg, input logic [7:0] b, input string tag);
        @(negedge clk);
        defs = d; legacy_mode = leg; byte_in = b; frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
        model_code = ref_code(d, leg);
        exp_q.push_back(merged(b, model_code));
        tag_q.push_back(tag);
        ->chk_ev;
        #1;
    endtask

    // Driver: change inputs without strobe; code must stay.
    task automatic nostrobe(input logic [5:0] d, input logic leg, input logic [7:0] b, input string tag);
        @(negedge clk);
        defs = d; legacy_mode = leg; byte_in = b;
        @(negedge clk);
        @(negedge clk);
        exp_q.push_back(merged(b, model_code));
        tag_q.push_back(tag);
        ->chk_ev;
        #1;
    endtask

    // Monitor: pop and compare.
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (byte_out !== e || rdi_code !== e[3:1]) begin
                    errors++;
                    $display("FAIL %s: byte_out=%h code=%b expected byte=%h code=%b",
                             t, byte_out, rdi_code, e, e[3:1]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_q.push_back(merged(8'h00, 3'b001)); tag_q.push_back("R1 reset code");
        ->chk_ev; #1;

        frame(6'b100000, 0, 8'hF1, "R2 AIS enhanced");
        frame(6'b010000, 0, 8'h00, "R2 LOP enhanced");
        frame(6'b001000, 0, 8'hA1, "R3 TIM enhanced");
        frame(6'b000100, 0, 8'h50, "R3 UNEQ enhanced");
        frame(6'b000010, 0, 8'hFF, "R4 PLM enhanced");
        frame(6'b000001, 0, 8'h0E, "R4 LCD shares payload code");
        frame(6'b000000, 0, 8'h3C, "R6 clear enhanced");
        for (int m = 1; m < 64; m++) begin
            frame(m[5:0], 0, 8'(m * 37), "R5 priority mix");
        end
        frame(6'b101011, 0, 8'h81, "R5 server over all");
        frame(6'b000110, 0, 8'h81, "R5 connect over payload");
        frame(6'b000000, 1, 8'h00, "R7 legacy clear");
        frame(6'b100000, 1, 8'hF0, "R7 legacy server");
        frame(6'b001100, 1, 8'h0F, "R7 legacy connect gives 000");
        frame(6'b000011, 1, 8'hAA, "R7 legacy payload gives 000");
        for (int m = 0; m < 64; m++) begin
            frame(m[5:0], 1, 8'(m * 11), "R7 legacy sweep");
        end
        frame(6'b000010, 0, 8'h11, "R4 before hold");
        nostrobe(6'b110000, 0, 8'hEE, "R8 server flag no strobe");
        nostrobe(6'b000000, 1, 8'h01, "R8 mode change no strobe");
        nostrobe(6'b001000, 0, 8'hFE, "R9 passthrough between frames");
        frame(6'b001000, 1, 8'h55, "R10 mode change at strobe");
        frame(6'b001000, 0, 8'hAA, "R10 back to enhanced");
        frame(6'b000000, 0, 8'hF1, "R9 field bits 3:1");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule